// File: doc/BRIEF.md
# Power-Down Request Filter Timer

This block sits next to the power management logic of one device function and decides when a power-down request has lasted long enough to be worth an interrupt. While the function holds its request line high, a counter measures the request against a window chosen by a 2-bit select. If the request is still high when the window ends, a level interrupt request is raised. A request that goes away early is forgotten without a trace.

Time is counted in units derived from a one-second tick input. A parameter divides that tick, so a bench or an emulation model can use a fast tick. A further parameter sets each of the three window lengths. Select code 00 switches the function off. Clearing the interrupt while the request is still held re-arms a fresh window.

A status output shows that a window is being timed. The interrupt output shows that a window has expired with the request still held.

Top module: `pd_filter_timer`

## Requirements
- R1: After reset both `pd_irq` and `filt_busy` are 0, the select is treated as 00 by the driver, and the tick divider phase is zero.
- R2: With `filt_sel` = 00 the block is held idle. `filt_busy` and `pd_irq` go to 0 on the edge after 00 is seen, from any state, and stay 0.
- R3: Each counted unit is TICK_DIV pulses of `sec_tick`. Code 01 selects a 4-unit window, 10 a 129-unit window and 11 a 518-unit window (parameters DLY_SHORT, DLY_MID, DLY_LONG).
- R4: In the idle state, a high `pd_req` with a nonzero select sets `filt_busy` on the next edge, and the count starts from zero.
- R5: If `pd_req` is low while counting, the block returns to idle on the next edge and raises no interrupt.
- R6: The edge that takes the last counted unit of the window, with the request still high and the select unchanged, sets `pd_irq` and clears `filt_busy`. `pd_irq` then stays 1 while the request stays high.
- R7: `pd_irq` falls on the edge after `pd_req` goes low or a one-cycle `irq_clr` pulse arrives. After a clear with the request still high, the block is idle for one cycle and then starts a new window.
- R8: A change of `filt_sel` to a different nonzero code while counting restarts the count from zero with the new window, and this takes priority over a unit tick in the same cycle. A nonzero change while `pd_irq` is high has no effect.
- R9: The tick divider runs freely from reset. It counts every `sec_tick` pulse whatever the state, and only every TICK_DIV-th pulse advances the window count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, nominally once per second |
| pd_req | input | 1 | Power-down request level from the function |
| filt_sel | input | 2 | Window select: 00 off, 01 short, 10 medium, 11 long |
| irq_clr | input | 1 | One-cycle pulse that clears the interrupt |
| pd_irq | output | 1 | Level interrupt request |
| filt_busy | output | 1 | High while a window is being timed |

## Verification
Two actions can land in the same cycle, and the bench provokes each pair directly. One pair is a select change on the very cycle that carries the final unit tick; here the restart must win, so `pd_irq` stays low and `filt_busy` stays high. The other pair is `irq_clr` arriving together with the request dropping; here the block must fall to idle with no re-arm on the next cycle. Random stimulus from a fixed seed also overlaps select changes, clears, ticks and request edges. Every cycle is compared against a bench model built from the requirements.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

    typedef enum logic [1:0] {
        PD_IDLE   = 2'd0,
        PD_COUNT  = 2'd1,
        PD_ASSERT = 2'd2
    } pd_state_e;

    localparam logic [1:0] SEL_OFF = 2'b00;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pdf_tick_div.sv
module pdf_tick_div #(
    parameter int unsigned TICK_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic unit_o
);
    localparam int unsigned DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

    logic [DW-1:0] div_d, div_q;
    logic          wrap;

    always_comb begin
        wrap  = tick_i && (div_q == LAST);
        div_d = div_q;
        if (tick_i) begin
            div_d = wrap ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign unit_o = wrap;

    // R9
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= LAST);

    // R9
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(div_q));

endmodule

// File: rtl/pdf_sel_decode.sv
module pdf_sel_decode #(
    parameter int unsigned CNT_W     = 10,
    parameter int unsigned DLY_SHORT = 4,
    parameter int unsigned DLY_MID   = 129,
    parameter int unsigned DLY_LONG  = 518
) (
    input  logic [1:0]       sel_i,
    output logic [CNT_W-1:0] limit_o
);
    always_comb begin
        unique case (sel_i)
            2'b01:   limit_o = CNT_W'(DLY_SHORT);
            2'b10:   limit_o = CNT_W'(DLY_MID);
            2'b11:   limit_o = CNT_W'(DLY_LONG);
            default: limit_o = '0;
        endcase
    end

endmodule

// File: rtl/pdf_filter_fsm.sv
module pdf_filter_fsm
    import pdf_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [1:0]       sel_i,
    input  logic             clr_i,
    input  logic             unit_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             irq_o,
    output logic             busy_o
);
    typedef struct packed {
        pd_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       sel;
    } regs_t;

    regs_t r_d, r_q;
    logic  sel_off;
    logic  last_unit;

    always_comb begin
        r_d       = r_q;
        sel_off   = (sel_i == SEL_OFF);
        last_unit = unit_i && (r_q.cnt == limit_i - 1'b1);
        unique case (r_q.st)
            PD_IDLE: begin
                if (!sel_off && req_i) begin
                    r_d.st  = PD_COUNT;
                    r_d.cnt = '0;
                    r_d.sel = sel_i;
                end
            end
            PD_COUNT: begin
                if (sel_off || !req_i) begin
                    r_d.st  = PD_IDLE;
                    r_d.cnt = '0;
                end else if (sel_i != r_q.sel) begin
                    r_d.cnt = '0;
                    r_d.sel = sel_i;
                end else if (last_unit) begin
                    r_d.st  = PD_ASSERT;
                    r_d.cnt = '0;
                end else if (unit_i) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            PD_ASSERT: begin
                if (sel_off || !req_i || clr_i) begin
                    r_d.st = PD_IDLE;
                end
            end
            default: begin
                r_d.st  = PD_IDLE;
                r_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= PD_IDLE;
            r_q.cnt <= '0;
            r_q.sel <= SEL_OFF;
        end else begin
            r_q <= r_d;
        end
    end

    assign irq_o  = (r_q.st == PD_ASSERT);
    assign busy_o = (r_q.st == PD_COUNT);

    // R2
    sel_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SEL_OFF) |=> (!irq_o && !busy_o));

    // R5
    req_drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !req_i) |=> (!busy_o && !irq_o));

    // R6
    irq_from_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(busy_o) && $past(unit_i) && $past(req_i)));

    // R7
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && clr_i) |=> !irq_o);

    // R8
    sel_change_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_i && (sel_i != SEL_OFF) && (sel_i != r_q.sel))
            |=> (busy_o && (r_q.cnt == '0)));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (sel_i == r_q.sel)) |-> (r_q.cnt < limit_i));

endmodule

// File: rtl/pd_filter_timer.sv
module pd_filter_timer
    import pdf_pkg::*;
#(
    parameter int unsigned TICK_DIV  = 1,
    parameter int unsigned DLY_SHORT = 4,
    parameter int unsigned DLY_MID   = 129,
    parameter int unsigned DLY_LONG  = 518
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       pd_req,
    input  logic [1:0] filt_sel,
    input  logic       irq_clr,
    output logic       pd_irq,
    output logic       filt_busy
);
    localparam int unsigned MAX_DLY = max3(DLY_SHORT, DLY_MID, DLY_LONG);
    localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1);

    logic             unit_tick;
    logic [CNT_W-1:0] limit;

    pdf_tick_div #(
        .TICK_DIV (TICK_DIV)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (sec_tick),
        .unit_o (unit_tick)
    );

    pdf_sel_decode #(
        .CNT_W     (CNT_W),
        .DLY_SHORT (DLY_SHORT),
        .DLY_MID   (DLY_MID),
        .DLY_LONG  (DLY_LONG)
    ) u_dec (
        .sel_i   (filt_sel),
        .limit_o (limit)
    );

    pdf_filter_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (pd_req),
        .sel_i   (filt_sel),
        .clr_i   (irq_clr),
        .unit_i  (unit_tick),
        .limit_i (limit),
        .irq_o   (pd_irq),
        .busy_o  (filt_busy)
    );

    // R7
    irq_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_irq && !pd_req) |=> !pd_irq);

endmodule

// File: tb/pd_filter_timer_tb.sv
module pd_filter_timer_tb;
    localparam int DIV = 2;
    localparam int DS  = 4;
    localparam int DM  = 129;
    localparam int DL  = 518;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       pd_req = 1'b0;
    logic [1:0] filt_sel = 2'b00;
    logic       irq_clr = 1'b0;
    logic       pd_irq, filt_busy;

    always #4 clk = ~clk;

    pd_filter_timer #(
        .TICK_DIV (DIV), .DLY_SHORT (DS), .DLY_MID (DM), .DLY_LONG (DL)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .sec_tick (sec_tick), .pd_req (pd_req),
        .filt_sel (filt_sel), .irq_clr (irq_clr),
        .pd_irq (pd_irq), .filt_busy (filt_busy)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string tag = "R1";
    int    m_st = 0, m_cnt = 0, m_sel = 0, m_div = 0;

    function automatic int win_len(input int s);
        return (s == 1) ? DS : (s == 2) ? DM : DL;
    endfunction

    task automatic chk(input string t, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", t, got, exp, $time);
        end
    endtask

    task automatic model_step();
        bit unit;
        unit = 1'b0;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_sel = 0; m_div = 0;
            return;
        end
        if (sec_tick) begin
            if (m_div == DIV - 1) begin unit = 1'b1; m_div = 0; end
            else m_div++;
        end
        case (m_st)
            0: if (filt_sel != 0 && pd_req) begin m_st = 1; m_cnt = 0; m_sel = filt_sel; end
            1: begin
                if (filt_sel == 0 || !pd_req) begin m_st = 0; m_cnt = 0; end
                else if (int'(filt_sel) != m_sel) begin m_cnt = 0; m_sel = filt_sel; end
                else if (unit) begin
                    if (m_cnt == win_len(m_sel) - 1) begin m_st = 2; m_cnt = 0; end
                    else m_cnt++;
                end
            end
            default: if (filt_sel == 0 || !pd_req || irq_clr) m_st = 0;
        endcase
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk({tag, " irq"}, pd_irq, m_st == 2);
        chk({tag, " busy"}, filt_busy, m_st == 1);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        run(3);
        chk("R1 reset irq", pd_irq, 1'b0);
        chk("R1 reset busy", filt_busy, 1'b0);
        rst_n = 1'b1;

        // R4 / R3 / R6: short window with continuous ticks
        tag = "R3 short"; filt_sel = 2'b01; sec_tick = 1'b1; pd_req = 1'b1;
        step();
        chk("R4 busy after request", filt_busy, 1'b1);
        run(20);
        chk("R6 irq held with request", pd_irq, 1'b1);

        // R7 drop by request, R5 early drop
        tag = "R5"; pd_req = 1'b0; step();
        chk("R7 irq drops with request", pd_irq, 1'b0);
        pd_req = 1'b1; run(3);
        pd_req = 1'b0; step();
        chk("R5 early drop busy", filt_busy, 1'b0);
        run(20);
        chk("R5 early drop no irq", pd_irq, 1'b0);

        // R3 medium window
        tag = "R3 mid"; filt_sel = 2'b10; pd_req = 1'b1; run(250);
        chk("R3 mid window not yet expired", pd_irq, 1'b0);
        run(20);
        chk("R3 mid window expired", pd_irq, 1'b1);

        // R8 nonzero change while asserted is ignored
        tag = "R8 asserted"; filt_sel = 2'b01; step();
        chk("R8 select change in asserted ignored", pd_irq, 1'b1);

        // R7 clear with request still held re-arms
        tag = "R7"; irq_clr = 1'b1; step(); irq_clr = 1'b0;
        chk("R7 clear drops irq", pd_irq, 1'b0);
        chk("R7 idle cycle after clear", filt_busy, 1'b0);
        step();
        chk("R7 re-armed after clear", filt_busy, 1'b1);

        // R8 restart to long window, then R3 long expiry
        tag = "R3 long"; run(3); filt_sel = 2'b11; step();
        chk("R8 restart keeps counting", filt_busy, 1'b1);
        run(1020);
        chk("R3 long window not yet expired", pd_irq, 1'b0);
        run(40);
        chk("R3 long window expired", pd_irq, 1'b1);

        // R2 select 00 forces idle from asserted
        tag = "R2"; filt_sel = 2'b00; step();
        chk("R2 off clears irq", pd_irq, 1'b0);
        run(30);
        chk("R2 off stays idle", filt_busy, 1'b0);

        // R8 select change on the final unit tick: restart wins
        tag = "R8 final"; filt_sel = 2'b01; sec_tick = 1'b0; step();
        while (!(m_cnt == DS - 1 && m_div == DIV - 1)) begin sec_tick = 1'b1; step(); end
        filt_sel = 2'b10; sec_tick = 1'b1; step();
        chk("R8 change on final tick keeps busy", filt_busy, 1'b1);
        chk("R8 change on final tick no irq", pd_irq, 1'b0);
        run(10);
        chk("R8 new window still running", pd_irq, 1'b0);

        // clear and request drop in the same cycle
        tag = "R7 same"; filt_sel = 2'b01; pd_req = 1'b0; step(); pd_req = 1'b1; run(20);
        chk("R6 irq before joint clear", pd_irq, 1'b1);
        irq_clr = 1'b1; pd_req = 1'b0; step(); irq_clr = 1'b0;
        chk("R7 joint clear irq", pd_irq, 1'b0);
        step();
        chk("R7 joint clear no re-arm", filt_busy, 1'b0);

        // R9 sparse ticks through the divider
        tag = "R9"; sec_tick = 1'b0; pd_req = 1'b1; step();
        for (int k = 0; k < 6; k++) begin sec_tick = 1'b1; step(); sec_tick = 1'b0; run(2); end
        chk("R9 six ticks too few", pd_irq, 1'b0);
        for (int k = 0; k < 4; k++) begin sec_tick = 1'b1; step(); sec_tick = 1'b0; run(2); end
        chk("R9 ten ticks enough", pd_irq, 1'b1);

        // random mix
        tag = "R8 random";
        for (int c = 0; c < 6000; c++) begin
            sec_tick = ($urandom % 2) == 0;
            if ($urandom % 48 == 0) pd_req = ~pd_req;
            if ($urandom % 300 == 0) filt_sel = 2'($urandom % 4);
            irq_clr = ($urandom % 90) == 0;
            step();
        end
        irq_clr = 1'b0;
        finish_up();
    end
endmodule